// File: doc/BRIEF.md
# Split-Domain Reset Generator

This block produces the internal resets of a network controller from one raw reset pin and two software-requested resets. A hardware reset clears everything: the core logic, the transceiver and the configuration registers. The two software requests are narrower. The core request resets the core logic but leaves the transceiver and the configuration registers untouched. The transceiver request resets the transceiver alone.

The pin is active low. It is synchronized to the clock and qualified by a minimum low time (`MIN_LOW_CYCLES`). A low pulse that is too short is rejected and reported on a one-cycle flag. A qualified reset is held for as long as the pin stays low. After the pin goes high, the reset is stretched through a two-stage release pipe before the outputs fall.

A software request holds its reset for `SW_CYCLES` clocks. Its request bit reads back as 1 for that whole time and then returns to 0 by itself. All outputs come from flops and are active high. `cfg_rst` goes high only for a hardware reset, so it also marks the times when the configuration registers are not preserved.

Top module: `chip_reset_ctrl`

## Requirements
- R1: When `pin_rst_n` stays low for at least `MIN_LOW_CYCLES + 3` clocks, `core_rst`, `xcvr_rst` and `cfg_rst` are all 1 while it stays low. Whenever `cfg_rst` is 1, the other two resets are also 1.
- R2: A low pulse on `pin_rst_n` shorter than `MIN_LOW_CYCLES - 2` clocks changes none of the three reset outputs. After the pin returns high, it raises `short_pulse` for exactly one clock.
- R3: After `pin_rst_n` returns high from a qualified reset, all three reset outputs fall on the same clock. That clock comes no sooner than 4 and no later than 8 clocks after the rise.
- R4: Writing 1 to the core request bit (`core_wr_en`=1 with `core_wr_bit`=1) raises `core_rst` for exactly `SW_CYCLES` consecutive clocks. `xcvr_rst` and `cfg_rst` stay 0 throughout.
- R5: `core_bit_rd` reads 1 on the clock after the core write. It returns to 0 by itself once the core reset has finished. While it reads 1, `core_rst` is 1 on the next clock.
- R6: Writing 1 to the transceiver request bit (`xcvr_wr_en`=1 with `xcvr_wr_bit`=1) raises `xcvr_rst` for exactly `SW_CYCLES` clocks. `core_rst` and `cfg_rst` stay 0 throughout.
- R7: `xcvr_bit_rd` reads 1 on the clock after the transceiver write and clears itself when the transceiver reset ends.
- R8: A write of 0 to either request bit has no effect. A write of 1 while that bit already reads 1 neither restarts nor extends the pulse.
- R9: A hardware reset overrides software resets. While `cfg_rst` is 1, both request bits read 0, and writes of 1 to either bit are ignored.
- R10: Both software requests may be written on the same clock. Each then produces its own `SW_CYCLES`-clock pulse, and the two pulses overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pin_rst_n | input | 1 | Raw hardware reset pin, active low, asynchronous to `clk` |
| core_wr_en | input | 1 | Write strobe for the core reset request bit |
| core_wr_bit | input | 1 | Value written to the core request bit |
| xcvr_wr_en | input | 1 | Write strobe for the transceiver reset request bit |
| xcvr_wr_bit | input | 1 | Value written to the transceiver request bit |
| core_rst | output | 1 | Core logic reset, active high |
| xcvr_rst | output | 1 | Transceiver reset, active high |
| cfg_rst | output | 1 | Configuration register reset, high only during a hardware reset |
| core_bit_rd | output | 1 | Readback of the core request bit |
| xcvr_bit_rd | output | 1 | Readback of the transceiver request bit |
| short_pulse | output | 1 | One-clock flag for a rejected, too-short pin pulse |

## Verification
The assertions check the domain relations on every clock:
- a hardware reset always covers both other domains;
- a reset output differs from `cfg_rst` only while its own request bit is set;
- a set bit is always followed by its reset;
- both bits are clear during a hardware reset;
- a bit never stays set longer than `SW_CYCLES`.

Only the bench scenarios can show the timing-dependent behaviour. These include qualifying or rejecting pulses by their length, the release latency after the pin rises, the exact software pulse width, and that writes of 0, repeated writes and writes during a hardware reset have no effect.

// File: rtl/chip_rst_pkg.sv
package chip_rst_pkg;

    // Depth of the pin synchronizer and of the release stretch pipe.
    localparam int SYNC_STAGES = 2;

    // One flag for each reset domain driven by the controller.
    typedef struct packed {
        logic core;
        logic xcvr;
        logic cfg;
    } rst_dom_t;

    // A hardware reset covers every domain; a software request covers only its own.
    function automatic rst_dom_t merge_dom(input logic hw, input logic core_sw, input logic xcvr_sw);
        rst_dom_t d;
        d.core = hw | core_sw;
        d.xcvr = hw | xcvr_sw;
        d.cfg  = hw;
        return d;
    endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual
    import chip_rst_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 5000000
) (
    input  logic clk,
    input  logic pin_n,
    output logic hw_active,
    output logic short_pulse
);
    localparam int CW = $clog2(MIN_LOW_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_LOW_CYCLES);
    localparam logic [CW-1:0] CNT_QUAL = CW'(MIN_LOW_CYCLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_lo;
    logic [CW-1:0]          low_cnt;
    logic                   hold_q;
    logic                   short_q;
    logic [SYNC_STAGES-1:0] stretch_q;

    // Two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
    end
    assign pin_lo = !sync_q[SYNC_STAGES-1];

    // Measure the low time and qualify it against the minimum.
    always_ff @(posedge clk) begin
        if (pin_lo) begin
            if (low_cnt < CNT_MAX) low_cnt <= low_cnt + 1'b1;
            if (low_cnt >= CNT_QUAL) hold_q <= 1'b1;
            short_q <= 1'b0;
        end else begin
            short_q <= (low_cnt != '0) && !hold_q;
            low_cnt <= '0;
            hold_q  <= 1'b0;
        end
    end

    // Release stretch: the reset stays on while the pipe drains.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stretch
            if (g == 0) begin : g_first
                always_ff @(posedge clk) stretch_q[g] <= hold_q;
            end else begin : g_next
                always_ff @(posedge clk) stretch_q[g] <= stretch_q[g-1];
            end
        end
    endgenerate

    assign hw_active   = hold_q | (|stretch_q);
    assign short_pulse = short_q;

endmodule

// File: rtl/rst_sw_pulse.sv
module rst_sw_pulse #(
    parameter int SW_CYCLES = 16
) (
    input  logic clk,
    input  logic hw_active,
    input  logic wr_en,
    input  logic wr_bit,
    output logic busy
);
    localparam int CW = (SW_CYCLES > 1) ? $clog2(SW_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SW_CYCLES - 1);

    logic          busy_q;
    logic [CW-1:0] left_q;

    // A hardware reset clears the bit. A write of 1 starts a pulse only when the bit is idle.
    always_ff @(posedge clk) begin
        if (hw_active) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (busy_q) begin
            if (left_q == '0) busy_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end else if (wr_en && wr_bit) begin
            busy_q <= 1'b1;
            left_q <= LAST;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/chip_reset_ctrl.sv
module chip_reset_ctrl
    import chip_rst_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 5000000,
    parameter int SW_CYCLES      = 16
) (
    input  logic clk,
    input  logic pin_rst_n,
    input  logic core_wr_en,
    input  logic core_wr_bit,
    input  logic xcvr_wr_en,
    input  logic xcvr_wr_bit,
    output logic core_rst,
    output logic xcvr_rst,
    output logic cfg_rst,
    output logic core_bit_rd,
    output logic xcvr_bit_rd,
    output logic short_pulse
);
    localparam int N_SW = 2;

    logic            hw_active;
    logic [N_SW-1:0] wr_en_v;
    logic [N_SW-1:0] wr_bit_v;
    logic [N_SW-1:0] busy_v;
    rst_dom_t        dom_q;

    rst_pin_qual #(.MIN_LOW_CYCLES(MIN_LOW_CYCLES)) u_pin (
        .clk         (clk),
        .pin_n       (pin_rst_n),
        .hw_active   (hw_active),
        .short_pulse (short_pulse)
    );

    // Index 0 is the core request, index 1 the transceiver request.
    assign wr_en_v  = {xcvr_wr_en, core_wr_en};
    assign wr_bit_v = {xcvr_wr_bit, core_wr_bit};

    genvar i;
    generate
        for (i = 0; i < N_SW; i++) begin : g_sw
            rst_sw_pulse #(.SW_CYCLES(SW_CYCLES)) u_sw (
                .clk       (clk),
                .hw_active (hw_active),
                .wr_en     (wr_en_v[i]),
                .wr_bit    (wr_bit_v[i]),
                .busy      (busy_v[i])
            );
        end
    endgenerate

    // Registered outputs, so the resets are glitch-free.
    always_ff @(posedge clk) begin
        dom_q <= merge_dom(hw_active, busy_v[0], busy_v[1]);
    end

    assign core_rst    = dom_q.core;
    assign xcvr_rst    = dom_q.xcvr;
    assign cfg_rst     = dom_q.cfg;
    assign core_bit_rd = busy_v[0];
    assign xcvr_bit_rd = busy_v[1];

endmodule

// File: rtl/chip_reset_ctrl_chk.sv
module chip_reset_ctrl_chk #(
    parameter int SW_CYCLES = 16
) (
    input logic clk,
    input logic core_rst,
    input logic xcvr_rst,
    input logic cfg_rst,
    input logic core_bit_rd,
    input logic xcvr_bit_rd
);
    logic        seen_hw = 1'b0;
    int unsigned core_run = 0;
    int unsigned xcvr_run = 0;

    // Enable the checks once the first hardware reset has been seen.
    always_ff @(posedge clk) begin
        seen_hw  <= seen_hw | cfg_rst;
        core_run <= core_bit_rd ? core_run + 1 : 0;
        xcvr_run <= xcvr_bit_rd ? xcvr_run + 1 : 0;
    end

    AST_HW_ALL_DOMAINS: assert property (@(posedge clk) disable iff (!seen_hw)
        cfg_rst |-> (core_rst && xcvr_rst)); // R1
    AST_CORE_OWN_ONLY: assert property (@(posedge clk) disable iff (!seen_hw)
        !core_bit_rd |=> (core_rst == cfg_rst)); // R4
    AST_XCVR_OWN_ONLY: assert property (@(posedge clk) disable iff (!seen_hw)
        !xcvr_bit_rd |=> (xcvr_rst == cfg_rst)); // R6
    AST_CORE_BIT_RESETS: assert property (@(posedge clk) disable iff (!seen_hw)
        core_bit_rd |=> core_rst); // R5
    AST_XCVR_BIT_RESETS: assert property (@(posedge clk) disable iff (!seen_hw)
        xcvr_bit_rd |=> xcvr_rst); // R7
    AST_HW_CLEARS_BITS: assert property (@(posedge clk) disable iff (!seen_hw)
        cfg_rst |-> (!core_bit_rd && !xcvr_bit_rd)); // R9
    AST_CORE_NO_EXTEND: assert property (@(posedge clk) disable iff (!seen_hw)
        core_bit_rd |-> (core_run < SW_CYCLES)); // R8
    AST_XCVR_NO_EXTEND: assert property (@(posedge clk) disable iff (!seen_hw)
        xcvr_bit_rd |-> (xcvr_run < SW_CYCLES)); // R8

endmodule

bind chip_reset_ctrl chip_reset_ctrl_chk #(.SW_CYCLES(SW_CYCLES)) u_chk (
    .clk         (clk),
    .core_rst    (core_rst),
    .xcvr_rst    (xcvr_rst),
    .cfg_rst     (cfg_rst),
    .core_bit_rd (core_bit_rd),
    .xcvr_bit_rd (xcvr_bit_rd)
);

// File: tb/chip_reset_ctrl_test.sv
module chip_reset_ctrl_test;
    localparam int MIN_LOW = 20;
    localparam int SW_CYC  = 16;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic pin_rst_n = 1'b0;
    logic core_wr_en = 1'b0, core_wr_bit = 1'b0;
    logic xcvr_wr_en = 1'b0, xcvr_wr_bit = 1'b0;
    logic core_rst, xcvr_rst, cfg_rst, core_bit_rd, xcvr_bit_rd, short_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    chip_reset_ctrl #(.MIN_LOW_CYCLES(MIN_LOW), .SW_CYCLES(SW_CYC)) uut (
        .clk(clk), .pin_rst_n(pin_rst_n),
        .core_wr_en(core_wr_en), .core_wr_bit(core_wr_bit),
        .xcvr_wr_en(xcvr_wr_en), .xcvr_wr_bit(xcvr_wr_bit),
        .core_rst(core_rst), .xcvr_rst(xcvr_rst), .cfg_rst(cfg_rst),
        .core_bit_rd(core_bit_rd), .xcvr_bit_rd(xcvr_bit_rd),
        .short_pulse(short_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Counts the high cycles of each output over n samples, starting at the current negedge.
    task automatic measure(input int n, output int c_hi, output int x_hi, output int g_hi,
                           output int both_hi);
        c_hi = 0; x_hi = 0; g_hi = 0; both_hi = 0;
        for (int k = 0; k < n; k++) begin
            c_hi += int'(core_rst);
            x_hi += int'(xcvr_rst);
            g_hi += int'(cfg_rst);
            both_hi += int'(core_rst && xcvr_rst);
            @(negedge clk);
        end
    endtask

    task automatic write_bits(input bit c_en, input bit c_bit, input bit x_en, input bit x_bit);
        core_wr_en = c_en; core_wr_bit = c_bit;
        xcvr_wr_en = x_en; xcvr_wr_bit = x_bit;
        @(negedge clk);
        core_wr_en = 0; core_wr_bit = 0; xcvr_wr_en = 0; xcvr_wr_bit = 0;
    endtask

    task automatic t_power_on;
        pin_rst_n = 1'b0;
        step(MIN_LOW + 10);
        check(core_rst == 1, "R1", "core_rst during hw reset", core_rst, 1);
        check(xcvr_rst == 1, "R1", "xcvr_rst during hw reset", xcvr_rst, 1);
        check(cfg_rst == 1,  "R1", "cfg_rst during hw reset", cfg_rst, 1);
        check(core_bit_rd == 0 && xcvr_bit_rd == 0, "R9", "bits during hw reset",
              core_bit_rd + xcvr_bit_rd, 0);
    endtask

    task automatic t_release;
        int lat;
        bit split;
        lat = 0; split = 0;
        pin_rst_n = 1'b1;
        @(negedge clk);
        lat = 1;
        while (core_rst && lat < 20) begin
            if (xcvr_rst != core_rst || cfg_rst != core_rst) split = 1;
            @(negedge clk);
            lat++;
        end
        if (xcvr_rst != core_rst || cfg_rst != core_rst) split = 1;
        check(lat >= 4 && lat <= 8, "R3", "release latency", lat, 6);
        check(!split, "R3", "domains fall together", int'(split), 0);
        step(4);
    endtask

    task automatic t_short;
        int c, x, g, b, flags;
        flags = 0;
        pin_rst_n = 1'b0;
        step(MIN_LOW - 5);
        pin_rst_n = 1'b1;
        c = 0; x = 0; g = 0;
        for (int k = 0; k < 12; k++) begin
            c += int'(core_rst); x += int'(xcvr_rst); g += int'(cfg_rst);
            flags += int'(short_pulse);
            @(negedge clk);
        end
        b = c + x + g;
        check(b == 0, "R2", "resets after short pulse", b, 0);
        check(flags == 1, "R2", "short_pulse cycles", flags, 1);
    endtask

    task automatic t_core_sw;
        int c, x, g, b;
        write_bits(1, 1, 0, 0);
        check(core_bit_rd == 1, "R5", "core bit after write", core_bit_rd, 1);
        measure(SW_CYC + 8, c, x, g, b);
        check(c == SW_CYC, "R4", "core_rst width", c, SW_CYC);
        check(x == 0, "R4", "xcvr_rst during core reset", x, 0);
        check(g == 0, "R4", "cfg_rst during core reset", g, 0);
        check(core_bit_rd == 0, "R5", "core bit self-clears", core_bit_rd, 0);
    endtask

    task automatic t_xcvr_sw;
        int c, x, g, b;
        write_bits(0, 0, 1, 1);
        check(xcvr_bit_rd == 1, "R7", "xcvr bit after write", xcvr_bit_rd, 1);
        measure(SW_CYC + 8, c, x, g, b);
        check(x == SW_CYC, "R6", "xcvr_rst width", x, SW_CYC);
        check(c == 0, "R6", "core_rst during xcvr reset", c, 0);
        check(g == 0, "R6", "cfg_rst during xcvr reset", g, 0);
        check(xcvr_bit_rd == 0, "R7", "xcvr bit self-clears", xcvr_bit_rd, 0);
    endtask

    task automatic t_ignore;
        int c, x, g, b;
        write_bits(1, 0, 1, 0);
        check(core_bit_rd == 0 && xcvr_bit_rd == 0, "R8", "bits after writing 0",
              core_bit_rd + xcvr_bit_rd, 0);
        measure(6, c, x, g, b);
        check(c + x == 0, "R8", "resets after writing 0", c + x, 0);
        // Re-write 1 in the middle of a pulse.
        write_bits(1, 1, 0, 0);
        c = 0;
        for (int k = 0; k < 5; k++) begin c += int'(core_rst); @(negedge clk); end
        core_wr_en = 1; core_wr_bit = 1;
        c += int'(core_rst);
        @(negedge clk);
        core_wr_en = 0; core_wr_bit = 0;
        measure(SW_CYC + 8, x, g, b, b);
        c += x;
        check(c == SW_CYC, "R8", "width with repeated write", c, SW_CYC);
    endtask

    task automatic t_hw_override;
        write_bits(1, 1, 1, 1);
        step(4);
        pin_rst_n = 1'b0;
        step(MIN_LOW + 6);
        check(core_bit_rd == 0 && xcvr_bit_rd == 0, "R9", "bits cleared by hw reset",
              core_bit_rd + xcvr_bit_rd, 0);
        check(cfg_rst == 1, "R1", "cfg_rst in override", cfg_rst, 1);
        write_bits(1, 1, 1, 1);
        check(core_bit_rd == 0 && xcvr_bit_rd == 0, "R9", "write during hw reset ignored",
              core_bit_rd + xcvr_bit_rd, 0);
        step(4);
        pin_rst_n = 1'b1;
        step(12);
        check(core_rst == 0 && xcvr_rst == 0 && cfg_rst == 0, "R9", "no reset after release",
              core_rst + xcvr_rst + cfg_rst, 0);
        check(core_bit_rd == 0 && xcvr_bit_rd == 0, "R9", "bits stay clear after release",
              core_bit_rd + xcvr_bit_rd, 0);
    endtask

    task automatic t_both;
        int c, x, g, b;
        write_bits(1, 1, 1, 1);
        check(core_bit_rd == 1 && xcvr_bit_rd == 1, "R10", "both bits set",
              core_bit_rd + xcvr_bit_rd, 2);
        measure(SW_CYC + 8, c, x, g, b);
        check(c == SW_CYC && x == SW_CYC, "R10", "both widths", c + x, 2 * SW_CYC);
        check(b == SW_CYC, "R10", "pulses overlap", b, SW_CYC);
        check(g == 0, "R10", "cfg_rst stays low", g, 0);
    endtask

    initial begin
        @(negedge clk);
        t_power_on();
        t_release();
        t_short();
        t_core_sw();
        t_xcvr_sw();
        t_ignore();
        t_hw_override();
        t_both();
        done = 1'b1;
    end

    initial begin
        for (int k = 0; k < WATCHDOG_CYCLES && !done; k++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule